// File: doc/BRIEF.md
# Comma-Aligning Word Deserializer

This block turns a retimed serial bit stream, one bit per bit clock, into 10-bit parallel words. Each word comes with a one-cycle valid strobe and a pair of complementary word-phase flags that mark the even and the odd word of a two-word group. The first bit received in a word lands on bit 0 of the parallel output.

When alignment is enabled, a sliding 10-bit window is examined on every bit clock for the positive-disparity comma prefix. The prefix is the received bit sequence 0,0,1,1,1,1,1, and the three bits that follow it are don't-care. If a comma turns up off the current word grid, the block remembers the new grid. It moves to that grid only after the odd word of the current two-word group, so the new grid starts with an even word. The move always lengthens the word period and never shortens it. The strobe keeps its nominal 10-bit rate at all other times.

A loss-of-signal input forces the presented word to all ones and masks the comma flag for as long as it is high. Clock recovery, analog sampling and line-code decoding are handled elsewhere.

Top module: `comma_deser`

## Requirements
- R1: Each word with `vld_o` high holds the 10 most recently received bits, with the oldest on `data_o[0]`. `vld_o` is high for exactly one bit clock, and without realignment it recurs every 10 bit clocks.
- R2: A comma is a word whose `data_o[6:0]` equals 7'b1111100 (bits 0 and 1 zero, bits 2 to 6 one). Bits 9:7 are ignored. `comma_o` is high with `vld_o` exactly when the presented word is a comma and loss-of-signal is low.
- R3: While `align_en_i` is low, no comma changes the word grid.
- R4: No two successive `vld_o` pulses are fewer than 10 bit clocks apart. A realignment produces a single period of 11 to 19 bit clocks.
- R5: After an off-grid comma, the switch to the new grid happens right after the next odd-phase word. The first word on the new grid is even. Later commas on that grid are presented with their first bit on `data_o[0]`.
- R6: While `los_i` is high, `data_o` reads 10'b1111111111 and `comma_o` is low.
- R7: `ph_even_o` and `ph_odd_o` are complementary. The first word after reset is even, the phase toggles with every word, and it changes only together with `vld_o`.
- R8: During and right after reset, `vld_o` and `comma_o` are low, `data_o` is zero (with `los_i` low) and `ph_even_o` is high.
- R9: A comma that already sits on the grid leaves the 10-bit period unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_i | input | 1 | Retimed serial bit |
| align_en_i | input | 1 | Enables comma search and realignment |
| los_i | input | 1 | Loss of signal; forces all-ones output |
| data_o | output | 10 | Parallel word, first received bit on bit 0 |
| vld_o | output | 1 | One-cycle word strobe |
| comma_o | output | 1 | Presented word carries the comma prefix |
| ph_even_o | output | 1 | Presented word is the even word of its group |
| ph_odd_o | output | 1 | Presented word is the odd word of its group |

## Verification
The bench puts a comma three bits off the grid and expects one strobe period of 13 bit clocks, placed directly after an odd word. A design that slivered the strobe would produce a short period, and one that switched at once would not wait for the odd word; either mismatches the recorded strobe positions. The same stream is replayed with alignment disabled, where a design that ignores the enable moves its grid. A comma already on the grid must leave every period at 10. Commas with varied trailing bits, carried in long random streams with loss-of-signal windows, catch a prefix compare that looks at the wrong bits or lets a comma through during loss.

// File: rtl/csd_pkg.sv
package csd_pkg;
    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } csd_phase_e;

    // Prefix as it sits in the low bits of a word: first received bit at bit 0.
    localparam int CSD_PREFIX_W = 7;
    localparam logic [CSD_PREFIX_W-1:0] CSD_PREFIX = 7'b1111100;
endpackage

// File: rtl/csd_window.sv
module csd_window #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_i,
    output logic [W-1:0] win_nxt_o,
    output logic         hit_o
);
    import csd_pkg::*;

    typedef struct packed {
        logic [W-1:0] win;
    } win_st_t;

    win_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.win = {ser_i, st_q.win[W-1:1]};
        win_nxt_o = st_d.win;
        hit_o = (st_d.win[CSD_PREFIX_W-1:0] == CSD_PREFIX);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/csd_strobe.sv
module csd_strobe #(
    parameter int W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic align_en_i,
    output logic strobe_o,
    output logic phase_o
);
    import csd_pkg::*;

    localparam int REM_W  = $clog2(2*W);
    localparam int TGT_W  = $clog2(W);
    localparam int STRETCH = 2*W - 2;

    typedef struct packed {
        logic [REM_W-1:0] rem;
        logic [TGT_W-1:0] tgt;
        logic             pend;
        csd_phase_e       ph;
    } strb_st_t;

    strb_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        strobe_o = (st_q.rem == '0);
        phase_o  = st_q.ph;

        st_d.tgt = (st_q.tgt == TGT_W'(W-1)) ? '0 : st_q.tgt + 1'b1;
        if (strobe_o) begin
            st_d.ph  = (st_q.ph == PH_EVEN) ? PH_ODD : PH_EVEN;
            st_d.rem = REM_W'(W-1);
        end else begin
            st_d.rem = st_q.rem - 1'b1;
        end

        if (!align_en_i) begin
            st_d.pend = 1'b0;
        end else if (hit_i) begin
            if (strobe_o) begin
                st_d.pend = 1'b0;
            end else begin
                st_d.pend = 1'b1;
                st_d.tgt  = '0;
            end
        end else if (strobe_o && st_q.pend && st_q.ph == PH_ODD) begin
            st_d.pend = 1'b0;
            st_d.rem  = REM_W'(STRETCH) - REM_W'(st_q.tgt);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rem  <= REM_W'(W-1);
            st_q.tgt  <= '0;
            st_q.pend <= 1'b0;
            st_q.ph   <= PH_EVEN;
        end else begin
            st_q <= st_d;
        end
    end

    assert_pend_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !align_en_i |=> !st_q.pend);
    assert_rem_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rem <= REM_W'(STRETCH));
endmodule

// File: rtl/comma_deser.sv
module comma_deser #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_i,
    input  logic         align_en_i,
    input  logic         los_i,
    output logic [W-1:0] data_o,
    output logic         vld_o,
    output logic         comma_o,
    output logic         ph_even_o,
    output logic         ph_odd_o
);
    import csd_pkg::*;

    localparam int GAP_W = $clog2(4*W);

    typedef struct packed {
        logic [W-1:0] data;
        logic         vld;
        logic         comma;
        csd_phase_e   ph;
    } out_st_t;

    out_st_t st_d, st_q;
    logic [W-1:0] win_nxt;
    logic         hit;
    logic         strobe;
    logic         phase;

    csd_window #(.W(W)) u_win (
        .clk(clk), .rst_n(rst_n), .ser_i(ser_i),
        .win_nxt_o(win_nxt), .hit_o(hit)
    );

    csd_strobe #(.W(W)) u_strb (
        .clk(clk), .rst_n(rst_n), .hit_i(hit), .align_en_i(align_en_i),
        .strobe_o(strobe), .phase_o(phase)
    );

    always_comb begin
        st_d = st_q;
        st_d.vld = strobe;
        if (strobe) begin
            st_d.data  = win_nxt;
            st_d.comma = hit;
            st_d.ph    = csd_phase_e'(phase);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.data  <= '0;
            st_q.vld   <= 1'b0;
            st_q.comma <= 1'b0;
            st_q.ph    <= PH_EVEN;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o    = los_i ? {W{1'b1}} : st_q.data;
    assign vld_o     = st_q.vld;
    assign comma_o   = st_q.comma & st_q.vld & ~los_i;
    assign ph_even_o = (st_q.ph == PH_EVEN);
    assign ph_odd_o  = (st_q.ph == PH_ODD);

    // Spacing monitor for the no-shortening rule.
    logic [GAP_W-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                        gap_q <= '0;
        else if (st_q.vld)                 gap_q <= GAP_W'(1);
        else if (gap_q != {GAP_W{1'b1}})   gap_q <= gap_q + 1'b1;
    end

    assert_gap_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> gap_q >= GAP_W'(W));
    assert_vld_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |=> !st_q.vld);
    assert_phase_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.vld |-> $stable(st_q.ph));
    assert_comma_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        comma_o |-> st_q.data[CSD_PREFIX_W-1:0] == CSD_PREFIX);
endmodule

// File: tb/tb_comma_deser.sv
module tb_comma_deser;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser = 1'b0;
    logic align_en = 1'b1;
    logic los = 1'b0;
    logic [9:0] data;
    logic vld, comma, ph_even, ph_odd;

    int n_chk = 0, n_err = 0;
    logic [9:0] shadow;
    int nbits, last_v;
    logic exp_odd;
    int vcnt [0:63];
    logic vcom [0:63];
    logic vev [0:63];
    int nv;
    bit done = 0;

    comma_deser dut (
        .clk(clk), .rst_n(rst_n), .ser_i(ser), .align_en_i(align_en), .los_i(los),
        .data_o(data), .vld_o(vld), .comma_o(comma), .ph_even_o(ph_even), .ph_odd_o(ph_odd)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic is_comma(input logic [9:0] w);
        return w[6:0] == 7'b1111100;
    endfunction

    task automatic observe();
        if (vld) begin
            int gap;
            gap = nbits - last_v;
            chk(data == (los ? 10'h3FF : shadow), "R1/R6 word", data, los ? 10'h3FF : shadow);
            chk(comma == (!los && is_comma(shadow)), "R2/R6 comma flag", comma, !los && is_comma(shadow));
            chk(ph_even == ~ph_odd, "R7 phase complement", ph_even, ~ph_odd);
            chk(ph_odd == exp_odd, "R7 phase toggle", ph_odd, exp_odd);
            chk(gap >= 10 && gap <= 19, "R4 period", gap, 10);
            exp_odd = ~exp_odd;
            last_v = nbits;
            if (nv < 64) begin
                vcnt[nv] = nbits; vcom[nv] = comma; vev[nv] = ph_even; nv++;
            end
        end else begin
            chk(comma == 1'b0, "R2 comma only with vld", comma, 0);
        end
    endtask

    task automatic step(input logic b);
        @(negedge clk);
        observe();
        ser = b;
        shadow = {b, shadow[9:1]};
        nbits++;
    endtask

    task automatic send_word(input logic [9:0] w);
        for (int i = 0; i < 10; i++) step(w[i]);
    endtask

    task automatic filler(input int n);
        for (int i = 0; i < n; i++) step(nbits[0]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ser = 1'b0; los = 1'b0;
        repeat (3) @(negedge clk);
        chk(vld == 1'b0, "R8 reset vld", vld, 0);
        chk(comma == 1'b0, "R8 reset comma", comma, 0);
        chk(data == 10'h000, "R8 reset data", data, 0);
        chk(ph_even == 1'b1, "R8 reset phase", ph_even, 1);
        rst_n = 1'b1;
        shadow = '0; nbits = 0; last_v = 0; exp_odd = 1'b0; nv = 0;
        // Drive first bit on this same negedge.
        ser = nbits[0]; shadow = {ser, shadow[9:1]}; nbits = 1;
    endtask

    function automatic int find_v(input int cnt);
        for (int i = 0; i < nv; i++) if (vcnt[i] == cnt) return i;
        return -1;
    endfunction

    localparam logic [9:0] COMMA = 10'b0101111100;

    initial begin
        int k;
        void'($urandom(32'd1234));

        // R5/R4: off-grid comma completing at bit 33.
        align_en = 1'b1;
        do_reset();
        filler(22); send_word(COMMA); filler(30); send_word(COMMA); filler(22);
        k = find_v(40);
        chk(k >= 0 && vev[k] == 1'b0, "R5 old grid odd word at 40", k, 1);
        chk(find_v(43) < 0, "R4 no sliver at 43", find_v(43), -1);
        k = find_v(53);
        chk(k >= 0, "R4 stretched strobe at 53", k, 1);
        chk(k >= 0 && vev[k] == 1'b1, "R5 new grid starts even", k >= 0 ? vev[k] : 0, 1);
        k = find_v(73);
        chk(k >= 0 && vcom[k] == 1'b1, "R5 comma aligned at bit 0", k, 1);

        // R3: same stream with alignment disabled.
        align_en = 1'b0;
        do_reset();
        filler(22); send_word(COMMA); filler(30); send_word(COMMA); filler(22);
        chk(find_v(50) >= 0, "R3 grid unchanged at 50", find_v(50), 1);
        chk(find_v(53) < 0, "R3 no move at 53", find_v(53), -1);
        chk(find_v(73) < 0, "R3 no comma word at 73", find_v(73), -1);

        // R9: comma already on the grid.
        align_en = 1'b1;
        do_reset();
        filler(19); send_word(10'b1011111100); filler(41);
        k = find_v(30);
        chk(k >= 0 && vcom[k] == 1'b1, "R9 on-grid comma reported", k, 1);
        chk(find_v(70) >= 0, "R9 period stays 10", find_v(70), 1);

        // R6: loss of signal window.
        do_reset();
        filler(15);
        los = 1'b1; send_word(COMMA); filler(12);
        chk(data == 10'h3FF, "R6 forced ones", data, 10'h3FF);
        chk(comma == 1'b0, "R6 comma masked", comma, 0);
        los = 1'b0; filler(25);

        // Random streams with mixed commas, enables and loss.
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 3) send_word({3'($urandom_range(0, 7)), 7'b1111100});
            else if (r < 4) align_en = ~align_en;
            else if (r < 5) los = ~los;
            else step(1'($urandom_range(0, 1)));
        end
        los = 1'b0;
        filler(30);

        done = 1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule